// File: doc/BRIEF.md
# Self-ID Packet Validator

After a serial-bus reset every node announces itself with self-identification quadlets. This block watches that stream, one 32-bit quadlet per `q_valid` strobe, with each self-ID quadlet followed by its bitwise inverse. It checks every quadlet as it arrives. When `phase_end` is pulsed, it publishes the topology results together: the node count, the local node number, the ID of the isochronous resource manager, and a 4-bit error code naming the first fault seen. A host-writable 10-bit bus number sits alongside these results and is never touched by a phase.

Quadlet layout, bit 31 first:
- [31:30] tag, which must be 01 or 10.
- [29:24] PHY ID.
- [23] extended flag; when it is clear the quadlet is a packet-0 quadlet.

A packet-0 quadlet also carries:
- [22] link-active.
- [21:16] gap count.
- [11] contender.
- [5:0] three 2-bit port fields, port 0 in [1:0]. A port field of 10 means the port leads to the parent.

An extended quadlet carries a sequence number in [22:20]. The results drive a status register directly.

Top module: `sid_validator`

## Requirements
- R1: After reset, `err_code`=0, `node_count`=0, `node_num`=3Fh, `irm_id`=3Fh and `bus_num`=3FFh.
- R2: A cycle with `bus_we` high loads `bus_wdata` into `bus_num` on the next edge. Phase completions never change `bus_num`.
- R3: If the quadlet in an inverse slot is not the exact bitwise inverse of the quadlet before it, the code is 0011.
- R4: If `phase_end` arrives while an inverse is still owed (an odd number of quadlets), the code is 0111.
- R5: Packet-0 PHY IDs must run 0, 1, 2, … in steps of one. The error codes are:
  - 0010 for an ID lower than expected, or for the ID 3Fh.
  - 0101 for an ID one above the expected value.
  - 0100 for an ID two or more above the expected value.
- R6: A self-ID quadlet whose tag is neither 01 nor 10 gives code 1000. Codes 1001–1110 never appear.
- R7: A packet-0 quadlet whose gap count differs from that of the first packet-0 quadlet of the phase gives code 1111.
- R8: An extended quadlet must carry the PHY ID of the preceding packet-0 quadlet and a sequence number of 0, 1, 2, … after that packet-0 quadlet. Any other extended quadlet, including one with no packet-0 before it, gives code 0110.
- R9: If the last packet-0 quadlet of the phase has any port field equal to 10, the code is 0001.
- R10: On an error-free phase, `node_count` becomes the last PHY ID plus one (0 if no packet-0 quadlet was seen), and `node_num` captures `local_phy_id`. Outputs change only on the edge that samples `phase_end`.
- R11: On an error-free phase, `irm_id` is the highest PHY ID whose packet-0 quadlet has both link-active and contender set. If no node qualifies, it is 3Fh.
- R12: Only the first fault in a phase is reported. Later faults in the same phase leave the code unchanged.
- R13: On a phase that ends with a nonzero code, `node_count` becomes 0 and both `node_num` and `irm_id` become 3Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Quadlet strobe |
| q_data | input | 32 | Received quadlet |
| phase_end | input | 1 | End of the self-ID phase; a quadlet in the same cycle is dropped |
| local_phy_id | input | 6 | This node's physical ID |
| bus_we | input | 1 | Bus number write strobe |
| bus_wdata | input | BUSW | Bus number write value |
| err_code | output | 4 | First fault code of the last phase |
| node_count | output | 6 | Nodes found in the last phase |
| node_num | output | 6 | Local node number |
| irm_id | output | 6 | Resource-manager node ID |
| bus_num | output | BUSW | Host bus number |

## Verification
The bench builds the block with its defaults: a 10-bit bus number that resets to 3FFh. With that width, an alternating write pattern reaches every bit of the field, and the reset value lands on all ones. The six-bit ID space lets a phase climb toward the all-ones ID, which is the value reserved to flag a bad ordering.

// File: rtl/sid_pkg.sv
package sid_pkg;
    localparam int QW       = 32;
    localparam int ID_W     = 6;
    localparam int GAP_W    = 6;
    localparam int SEQ_W    = 3;
    localparam int NPORT    = 3;
    localparam int ERR_W    = 4;

    localparam logic [ID_W-1:0] ID_NONE = '1;
    localparam logic [1:0]      PORT_PARENT = 2'b10;

    localparam logic [ERR_W-1:0] ERR_NONE   = 4'h0;
    localparam logic [ERR_W-1:0] ERR_ROOT   = 4'h1;
    localparam logic [ERR_W-1:0] ERR_ORDER  = 4'h2;
    localparam logic [ERR_W-1:0] ERR_INV    = 4'h3;
    localparam logic [ERR_W-1:0] ERR_TWOGAP = 4'h4;
    localparam logic [ERR_W-1:0] ERR_ONEGAP = 4'h5;
    localparam logic [ERR_W-1:0] ERR_EXTID  = 4'h6;
    localparam logic [ERR_W-1:0] ERR_PAIR   = 4'h7;
    localparam logic [ERR_W-1:0] ERR_TAG    = 4'h8;
    localparam logic [ERR_W-1:0] ERR_GAP    = 4'hF;

    typedef struct packed {
        logic [1:0]       tag;
        logic [ID_W-1:0]  phy;
        logic             ext;
        logic             link;
        logic [GAP_W-1:0] gap;
        logic [3:0]       pad0;
        logic             contend;
        logic [4:0]       pad1;
        logic [2*NPORT-1:0] ports;
    } sid_quad_t;

    function automatic logic tag_ok(input logic [1:0] t);
        return (t == 2'b01) || (t == 2'b10);
    endfunction

    function automatic logic [SEQ_W-1:0] ext_seq(input logic [QW-1:0] q);
        return q[22:20];
    endfunction
endpackage

// File: rtl/sid_pair_track.sv
module sid_pair_track
    import sid_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          q_valid,
    input  logic [QW-1:0] q_data,
    input  logic          phase_end,
    output logic          data_stb,
    output logic          inv_bad,
    output logic          pending
);
    logic          pend_q;
    logic [QW-1:0] held_q;

    assign data_stb = q_valid && !phase_end && !pend_q;
    assign inv_bad  = q_valid && !phase_end && pend_q && (q_data != ~held_q);
    assign pending  = pend_q;

    always_ff @(posedge clk) begin
        if (rst || phase_end) begin
            pend_q <= 1'b0;
        end else if (q_valid) begin
            pend_q <= !pend_q;
        end
        if (rst) begin
            held_q <= '0;
        end else if (data_stb) begin
            held_q <= q_data;
        end
    end

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        phase_end |=> !pending);  // R4
endmodule

// File: rtl/sid_seq_check.sv
module sid_seq_check
    import sid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_end,
    input  logic             data_stb,
    input  logic [QW-1:0]    q_data,
    output logic [ERR_W-1:0] quad_err,
    output logic [ID_W-1:0]  node_total,
    output logic [ID_W-1:0]  irm_cand,
    output logic             root_bad
);
    sid_quad_t        q;
    logic             have_q;
    logic [ID_W-1:0]  last_q;
    logic [GAP_W-1:0] gap_q;
    logic [SEQ_W-1:0] seq_q;
    logic             irm_ok_q;
    logic [ID_W-1:0]  irm_q;
    logic             root_q;
    logic [ID_W:0]    exp_id;
    logic [ID_W:0]    cur_id;
    logic [NPORT-1:0] par_vec;

    assign q      = sid_quad_t'(q_data);
    assign exp_id = have_q ? ({1'b0, last_q} + 1'b1) : '0;
    assign cur_id = {1'b0, q.phy};

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign par_vec[i] = (q.ports[2*i +: 2] == PORT_PARENT);
    end

    always_comb begin
        quad_err = ERR_NONE;
        if (data_stb) begin
            if (!tag_ok(q.tag)) begin
                quad_err = ERR_TAG;
            end else if (!q.ext) begin
                if (q.phy == ID_NONE || cur_id < exp_id)
                    quad_err = ERR_ORDER;
                else if (cur_id == exp_id + 1'b1)
                    quad_err = ERR_ONEGAP;
                else if (cur_id > exp_id + 1'b1)
                    quad_err = ERR_TWOGAP;
                else if (have_q && q.gap != gap_q)
                    quad_err = ERR_GAP;
            end else begin
                if (!have_q || q.phy != last_q || ext_seq(q_data) != seq_q)
                    quad_err = ERR_EXTID;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || phase_end) begin
            have_q   <= 1'b0;
            last_q   <= '0;
            gap_q    <= '0;
            seq_q    <= '0;
            irm_ok_q <= 1'b0;
            irm_q    <= '0;
            root_q   <= 1'b0;
        end else if (data_stb && quad_err == ERR_NONE) begin
            if (!q.ext) begin
                have_q <= 1'b1;
                last_q <= q.phy;
                seq_q  <= '0;
                root_q <= |par_vec;
                if (!have_q) gap_q <= q.gap;
                if (q.link && q.contend) begin
                    irm_ok_q <= 1'b1;
                    irm_q    <= q.phy;
                end
            end else begin
                seq_q <= seq_q + 1'b1;
            end
        end
    end

    assign node_total = have_q ? last_q + 1'b1 : '0;
    assign irm_cand   = irm_ok_q ? irm_q : ID_NONE;
    assign root_bad   = root_q;

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        !(quad_err > ERR_TAG && quad_err < ERR_GAP));  // R6
    AST_IDS_RISE: assert property (@(posedge clk) disable iff (rst)
        (have_q && !phase_end && !(data_stb && quad_err == ERR_NONE && !q.ext))
        |=> $stable(last_q));  // R5
endmodule

// File: rtl/sid_result.sv
module sid_result
    import sid_pkg::*;
#(
    parameter int              BUSW     = 10,
    parameter logic [BUSW-1:0] BUS_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_end,
    input  logic [ERR_W-1:0] quad_err,
    input  logic             inv_bad,
    input  logic             pending,
    input  logic             root_bad,
    input  logic [ID_W-1:0]  node_total,
    input  logic [ID_W-1:0]  irm_cand,
    input  logic [ID_W-1:0]  local_phy_id,
    input  logic             bus_we,
    input  logic [BUSW-1:0]  bus_wdata,
    output logic [ERR_W-1:0] err_code,
    output logic [ID_W-1:0]  node_count,
    output logic [ID_W-1:0]  node_num,
    output logic [ID_W-1:0]  irm_id,
    output logic [BUSW-1:0]  bus_num
);
    logic [ERR_W-1:0] first_q;
    logic [ERR_W-1:0] final_err;

    always_comb begin
        if (first_q != ERR_NONE)  final_err = first_q;
        else if (pending)         final_err = ERR_PAIR;
        else if (root_bad)        final_err = ERR_ROOT;
        else                      final_err = ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst || phase_end) begin
            first_q <= ERR_NONE;
        end else if (first_q == ERR_NONE) begin
            if (inv_bad)                   first_q <= ERR_INV;
            else if (quad_err != ERR_NONE) first_q <= quad_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_code   <= ERR_NONE;
            node_count <= '0;
            node_num   <= ID_NONE;
            irm_id     <= ID_NONE;
        end else if (phase_end) begin
            err_code <= final_err;
            if (final_err == ERR_NONE) begin
                node_count <= node_total;
                node_num   <= local_phy_id;
                irm_id     <= irm_cand;
            end else begin
                node_count <= '0;
                node_num   <= ID_NONE;
                irm_id     <= ID_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_num <= BUS_INIT;
        else if (bus_we) bus_num <= bus_wdata;
    end

    AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (first_q != ERR_NONE && !phase_end) |=> first_q == $past(first_q));  // R12
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(bus_num));  // R2
    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !phase_end |=> ($stable(err_code) && $stable(node_count) && $stable(irm_id)));  // R10
endmodule

// File: rtl/sid_validator.sv
module sid_validator
    import sid_pkg::*;
#(
    parameter int              BUSW     = 10,
    parameter logic [BUSW-1:0] BUS_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_valid,
    input  logic [QW-1:0]    q_data,
    input  logic             phase_end,
    input  logic [ID_W-1:0]  local_phy_id,
    input  logic             bus_we,
    input  logic [BUSW-1:0]  bus_wdata,
    output logic [ERR_W-1:0] err_code,
    output logic [ID_W-1:0]  node_count,
    output logic [ID_W-1:0]  node_num,
    output logic [ID_W-1:0]  irm_id,
    output logic [BUSW-1:0]  bus_num
);
    logic             data_stb;
    logic             inv_bad;
    logic             pending;
    logic [ERR_W-1:0] quad_err;
    logic [ID_W-1:0]  node_total;
    logic [ID_W-1:0]  irm_cand;
    logic             root_bad;

    sid_pair_track u_pair (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_data(q_data),
        .phase_end(phase_end), .data_stb(data_stb), .inv_bad(inv_bad),
        .pending(pending)
    );

    sid_seq_check u_seq (
        .clk(clk), .rst(rst), .phase_end(phase_end), .data_stb(data_stb),
        .q_data(q_data), .quad_err(quad_err), .node_total(node_total),
        .irm_cand(irm_cand), .root_bad(root_bad)
    );

    sid_result #(.BUSW(BUSW), .BUS_INIT(BUS_INIT)) u_res (
        .clk(clk), .rst(rst), .phase_end(phase_end), .quad_err(quad_err),
        .inv_bad(inv_bad), .pending(pending), .root_bad(root_bad),
        .node_total(node_total), .irm_cand(irm_cand),
        .local_phy_id(local_phy_id), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .err_code(err_code), .node_count(node_count), .node_num(node_num),
        .irm_id(irm_id), .bus_num(bus_num)
    );

    AST_ERR_FORCES: assert property (@(posedge clk) disable iff (rst)
        (err_code != 4'h0) |-> (node_count == 6'd0 && irm_id == 6'h3F));  // R13
endmodule

// File: tb/sim_sid_validator.sv
module sim_sid_validator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        q_valid = 1'b0;
    logic [31:0] q_data = '0;
    logic        phase_end = 1'b0;
    logic [5:0]  local_phy_id = '0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_wdata = '0;
    logic [3:0]  err_code;
    logic [5:0]  node_count, node_num, irm_id;
    logic [9:0]  bus_num;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sid_validator u0 (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_data(q_data),
        .phase_end(phase_end), .local_phy_id(local_phy_id), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .err_code(err_code), .node_count(node_count),
        .node_num(node_num), .irm_id(irm_id), .bus_num(bus_num)
    );

    // behavioural reference model
    int m_pend, m_last, m_gap, m_seq, m_irm, m_root, m_err;
    logic [31:0] m_held;
    int e_err = 0, e_cnt = 0, e_num = 63, e_irm = 63, e_bus = 1023;

    task automatic m_clear();
        m_pend = 0; m_last = -1; m_gap = 0; m_seq = 0;
        m_irm = 63; m_root = 0; m_err = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_clear();
            e_err = 0; e_cnt = 0; e_num = 63; e_irm = 63; e_bus = 1023;
        end else begin
            if (bus_we) e_bus = bus_wdata;
            if (phase_end) begin
                int fin;
                fin = (m_err != 0) ? m_err : (m_pend != 0) ? 7 : (m_root != 0) ? 1 : 0;
                e_err = fin;
                if (fin == 0) begin
                    e_cnt = m_last + 1; e_num = local_phy_id; e_irm = m_irm;
                end else begin
                    e_cnt = 0; e_num = 63; e_irm = 63;
                end
                m_clear();
            end else if (q_valid) begin
                if (m_pend != 0) begin
                    if (q_data !== ~m_held && m_err == 0) m_err = 3;
                    m_pend = 0;
                end else begin
                    int c, id, tg;
                    m_pend = 1; m_held = q_data;
                    tg = q_data[31:30]; id = q_data[29:24]; c = 0;
                    if (tg != 1 && tg != 2) c = 8;
                    else if (q_data[23] == 1'b0) begin
                        if (id == 63 || id < m_last + 1) c = 2;
                        else if (id == m_last + 2) c = 5;
                        else if (id > m_last + 2) c = 4;
                        else if (m_last >= 0 && q_data[21:16] != m_gap) c = 15;
                    end else begin
                        if (m_last < 0 || id != m_last || q_data[22:20] != m_seq) c = 6;
                    end
                    if (m_err == 0) m_err = c;
                    if (c == 0) begin
                        if (q_data[23] == 1'b0) begin
                            if (m_last < 0) m_gap = q_data[21:16];
                            m_last = id; m_seq = 0;
                            m_root = (q_data[1:0] == 2 || q_data[3:2] == 2 || q_data[5:4] == 2) ? 1 : 0;
                            if (q_data[22] && q_data[11]) m_irm = id;
                        end else m_seq = m_seq + 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk("R12", "err_code(model)", err_code, e_err);
            chk("R10", "node_count(model)", node_count, e_cnt);
            chk("R10", "node_num(model)", node_num, e_num);
            chk("R11", "irm_id(model)", irm_id, e_irm);
            chk("R2", "bus_num(model)", bus_num, e_bus);
        end
    end

    function automatic logic [31:0] p0(input int id, input bit lk, input int gap,
                                        input bit ct, input logic [5:0] ports);
        return {2'b10, 6'(id), 1'b0, lk, 6'(gap), 4'b0, ct, 5'b0, ports};
    endfunction

    function automatic logic [31:0] ext(input int id, input int seq);
        return {2'b10, 6'(id), 1'b1, 3'(seq), 20'h0};
    endfunction

    localparam logic [5:0] PAR  = 6'b00_00_10;
    localparam logic [5:0] ROOT = 6'b00_11_11;

    task automatic send(input logic [31:0] q);
        @(negedge clk); q_valid = 1'b1; q_data = q;
        @(negedge clk); q_valid = 1'b0;
    endtask

    task automatic pair(input logic [31:0] q);
        send(q); send(~q);
    endtask

    task automatic finish_phase();
        @(negedge clk); phase_end = 1'b1;
        @(negedge clk); phase_end = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1", "err_code", err_code, 0);
        chk("R1", "node_count", node_count, 0);
        chk("R1", "node_num", node_num, 6'h3F);
        chk("R1", "irm_id", irm_id, 6'h3F);
        chk("R1", "bus_num", bus_num, 10'h3FF);

        // R10 R11 R8: clean three-node phase with extended quadlets
        local_phy_id = 6'd2;
        pair(p0(0, 0, 5, 0, PAR));
        pair(p0(1, 1, 5, 1, PAR));
        pair(ext(1, 0));
        pair(ext(1, 1));
        pair(p0(2, 1, 5, 0, ROOT));
        finish_phase();
        chk("R10", "node_count", node_count, 3);
        chk("R10", "node_num", node_num, 2);
        chk("R11", "irm_id", irm_id, 1);
        chk("R8", "err_code clean", err_code, 0);

        // R2 bus number write, then a phase leaves it alone
        @(negedge clk); bus_we = 1'b1; bus_wdata = 10'h155;
        @(negedge clk); bus_we = 1'b0;
        pair(p0(0, 0, 1, 0, ROOT));
        finish_phase();
        chk("R2", "bus_num", bus_num, 10'h155);
        chk("R11", "irm none", irm_id, 6'h3F);
        chk("R10", "single node", node_count, 1);

        // R3 R12 R13 bad inverse, later order fault ignored
        send(p0(0, 0, 1, 0, PAR)); send(32'h0);
        pair(p0(5, 0, 1, 0, ROOT));
        finish_phase();
        chk("R3", "err_code", err_code, 4'h3);
        chk("R13", "node_count", node_count, 0);
        chk("R13", "node_num", node_num, 6'h3F);

        // R4 odd ending
        pair(p0(0, 0, 1, 0, PAR));
        send(p0(1, 0, 1, 0, ROOT));
        finish_phase();
        chk("R4", "err_code", err_code, 4'h7);

        // R5 ordering faults
        pair(p0(0, 0, 1, 0, PAR)); pair(p0(0, 0, 1, 0, ROOT)); finish_phase();
        chk("R5", "repeat id", err_code, 4'h2);
        pair(p0(0, 0, 1, 0, PAR)); pair(p0(2, 0, 1, 0, ROOT)); finish_phase();
        chk("R5", "one gap", err_code, 4'h5);
        pair(p0(0, 0, 1, 0, PAR)); pair(p0(3, 0, 1, 0, ROOT)); finish_phase();
        chk("R5", "two gaps", err_code, 4'h4);
        pair(p0(1, 0, 1, 0, ROOT)); finish_phase();
        chk("R5", "start not zero", err_code, 4'h5);

        // R6 bad tag
        pair({2'b11, p0(0, 0, 1, 0, ROOT)[29:0]}); finish_phase();
        chk("R6", "tag 11", err_code, 4'h8);

        // R7 gap count mismatch
        pair(p0(0, 0, 4, 0, PAR)); pair(p0(1, 0, 6, 0, ROOT)); finish_phase();
        chk("R7", "gap", err_code, 4'hF);

        // R8 extended faults
        pair(p0(0, 0, 1, 0, ROOT)); pair(ext(1, 0)); finish_phase();
        chk("R8", "ext id", err_code, 4'h6);
        pair(p0(0, 0, 1, 0, ROOT)); pair(ext(0, 1)); finish_phase();
        chk("R8", "ext seq", err_code, 4'h6);
        pair(ext(0, 0)); finish_phase();
        chk("R8", "ext first", err_code, 4'h6);

        // R9 last node has a parent
        pair(p0(0, 1, 1, 1, ROOT)); pair(p0(1, 0, 1, 0, PAR)); finish_phase();
        chk("R9", "root", err_code, 4'h1);
        chk("R13", "irm on error", irm_id, 6'h3F);

        // R10 empty phase, R11 highest contender wins
        finish_phase();
        chk("R10", "empty count", node_count, 0);
        chk("R10", "empty err", err_code, 0);
        local_phy_id = 6'd7;
        pair(p0(0, 1, 2, 1, PAR)); pair(p0(1, 0, 2, 1, PAR));
        pair(p0(2, 1, 2, 1, PAR)); pair(p0(3, 1, 2, 0, ROOT));
        finish_phase();
        chk("R11", "highest", irm_id, 2);
        chk("R10", "node_num", node_num, 7);
        chk("R2", "bus kept", bus_num, 10'h155);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule